// File: doc/BRIEF.md
# Strip Channel Zero-Suppressor with Neighbour Readout

This block reduces the data from a row of strip channels to the channels that matter. Each channel's digitised samples arrive already summed, one channel per cycle in increasing index order. The block subtracts that channel's stored baseline, which gives the auto-zero. It clamps a negative result to zero and compares the corrected sum with a threshold. A channel above threshold is forwarded. So are the channels directly to its left and right, because the charge of one particle usually spreads over adjacent strips.

A channel is kept in a small window until the next channel has arrived. By then both of its neighbours are known, and the keep-or-drop decision is made once for each channel. A channel that sits between two hits, or that is a hit and also a neighbour, is therefore sent only once. The last channel of the row is decided as soon as it arrives, so the end of a scan never waits for more input. Each forwarded record carries the value of a free-running time counter, taken when its channel was accepted. When the consumer stops taking records, the block stops taking channels, and nothing is lost.

Baselines are held in a table with one entry per channel. The table is cleared by reset and loaded through a single-cycle write port.

Top module: `strip_sparsifier`

## Requirements
- R1: A channel is a hit only when its corrected sum is strictly greater than `thresh`; a corrected sum equal to `thresh` is not a hit.
- R2: The corrected sum is `in_sum` minus the stored baseline of `in_chan` when that difference is non-negative, and 0 otherwise; the record's value field carries this corrected sum.
- R3: A write with `ped_we` high stores `ped_data` at `ped_addr`, and channels accepted after that clock edge use the new value; reset sets every baseline to 0.
- R4: A channel is forwarded when it is a hit, or when channel index-1 or index+1 is a hit and was presented as the adjacent channel in the same stream.
- R5: Each accepted channel is forwarded at most once, and records leave in the order in which their channels were accepted.
- R6: Channel 0 has only a right neighbour and channel N_CH-1 has only a left neighbour. No record carries an index that was never presented. The last channel is decided without waiting for further input.
- R7: `out_word` is {channel index in bits 36:30, corrected sum in bits 29:16, time tag in bits 15:0}. The time tag is the `time_cnt` value at the clock edge on which that channel was accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_word` holds and `in_ready` is low. No record is dropped.
- R9: After reset, `out_valid` is low, `in_ready` is high, and no channel is held in the window.
- R10: A channel that is not a hit and has no hit neighbour produces no record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A channel sum is presented |
| in_ready | output | 1 | The block accepts the presented channel this cycle |
| in_chan | input | 7 | Index of the presented channel |
| in_sum | input | 14 | Sum of that channel's 10-bit samples |
| thresh | input | 14 | Hit threshold, applied to the corrected sum |
| time_cnt | input | 16 | Free-running time counter |
| ped_we | input | 1 | Baseline write strobe |
| ped_addr | input | 7 | Channel whose baseline is written |
| ped_data | input | 14 | Baseline value to store |
| out_valid | output | 1 | A record is presented |
| out_ready | input | 1 | The consumer takes the record |
| out_word | output | 37 | {channel, corrected sum, time tag} |

## Verification
The assertions check the stream discipline on every cycle. A stalled record must keep both its valid flag and its contents. A stall must hold the input side closed. An empty output stage must accept input. Nothing may be presented just after reset. Which channels appear, and with which value and tag, depends on the whole pattern of hits along the row. Only the bench's scans can show that: isolated hits, hits at both edges, hits that share a neighbour, runs of adjacent hits, a clamped baseline and a sum exactly at threshold, some of them under backpressure.

// File: rtl/strip_sparse_pkg.sv
// Package: constants shared by the strip zero-suppressor and its bench.
// Assumes one sample code is SAMP_W bits wide; the sum width follows from
// the number of samples summed per channel.
package strip_sparse_pkg;
    localparam int SAMP_W     = 10;
    localparam int N_CH_DEF   = 128;
    localparam int N_SAMP_DEF = 16;
    localparam int TAG_W_DEF  = 16;

    // Width that holds the sum of n samples of w bits each
    function automatic int sum_width(input int w, input int n);
        return w + $clog2(n);
    endfunction
endpackage

// File: rtl/strip_ped_table.sv
// Module: per-channel baseline store. Written one entry per cycle and read
// combinationally by the channel index that is being presented.
// Assumes the read index is always below N_CH. Reset clears every entry.
module strip_ped_table #(
    parameter int N_CH  = 128,
    parameter int CH_W  = 7,
    parameter int SUM_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_addr,
    input  logic [SUM_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_addr,
    output logic [SUM_W-1:0] rd_data
);
    logic [SUM_W-1:0] base_q [N_CH];

    // One register per channel: cleared on reset, loaded on an address match
    for (genvar g = 0; g < N_CH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[g] <= '0;
            else if (wr_en && (wr_addr == CH_W'(g)))
                base_q[g] <= wr_data;
        end
    end

    // Combinational read of the presented channel's baseline
    always_comb begin
        rd_data = base_q[rd_addr];
    end
endmodule

// File: rtl/strip_autozero.sv
// Module: baseline subtraction with clamp at zero, then the threshold test.
// Purely combinational. Assumes sum and baseline are unsigned.
module strip_autozero #(
    parameter int SUM_W = 14
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [SUM_W-1:0] base,
    input  logic [SUM_W-1:0] thresh,
    output logic [SUM_W-1:0] corr,
    output logic             hit
);
    // Corrected sum: the difference, or zero when the baseline is larger
    always_comb begin
        corr = (sum >= base) ? (sum - base) : '0;
    end

    // Hit only when the corrected sum lies strictly above the threshold
    always_comb begin
        hit = (corr > thresh);
    end
endmodule

// File: rtl/strip_nbr_window.sv
// Module: three-channel window with the output register. The middle channel
// is decided once: when the next channel arrives, which gives the look-ahead,
// or at once when it is the last channel. The previously decided channel
// gives the look-behind. Adjacency is tested on the indices, widened by one
// bit so that the last channel is never taken as the neighbour of channel 0.
// Assumes the channels of one scan arrive in increasing index order.
module strip_nbr_window #(
    parameter int N_CH  = 128,
    parameter int CH_W  = 7,
    parameter int SUM_W = 14,
    parameter int TAG_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [CH_W-1:0]             in_chan,
    input  logic [SUM_W-1:0]            in_corr,
    input  logic                        in_hit,
    input  logic [TAG_W-1:0]            in_tag,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [CH_W+SUM_W+TAG_W-1:0] out_word
);
    localparam int        XW   = CH_W + 1;
    localparam [XW-1:0]   LAST = XW'(N_CH - 1);
    localparam [XW-1:0]   ONE  = XW'(1);

    logic              mid_v, mid_hit;
    logic [CH_W-1:0]   mid_chan;
    logic [SUM_W-1:0]  mid_corr;
    logic [TAG_W-1:0]  mid_tag;
    logic              prv_v, prv_hit;
    logic [CH_W-1:0]   prv_chan;
    logic              ovld_q;
    logic [CH_W+SUM_W+TAG_W-1:0] oword_q;

    logic out_free, in_fire, mid_last, decide, ahead, behind, emit;

    // Handshake: the input moves only while the output stage can take a record
    always_comb begin
        out_free = !ovld_q || out_ready;
        in_ready = out_free;
        in_fire  = in_valid && out_free;
    end

    // Decision on the middle channel from its own hit and both neighbours
    always_comb begin
        mid_last = ({1'b0, mid_chan} == LAST);
        decide   = mid_v && (in_fire || (mid_last && out_free));
        ahead    = in_fire && in_hit &&
                   ({1'b0, in_chan} == ({1'b0, mid_chan} + ONE));
        behind   = prv_v && prv_hit &&
                   (({1'b0, prv_chan} + ONE) == {1'b0, mid_chan});
        emit     = decide && (mid_hit || ahead || behind);
    end

    // Middle slot: load each accepted channel, empty it after a flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_v    <= 1'b0;
            mid_hit  <= 1'b0;
            mid_chan <= '0;
            mid_corr <= '0;
            mid_tag  <= '0;
        end else if (in_fire) begin
            mid_v    <= 1'b1;
            mid_hit  <= in_hit;
            mid_chan <= in_chan;
            mid_corr <= in_corr;
            mid_tag  <= in_tag;
        end else if (decide) begin
            mid_v    <= 1'b0;
        end
    end

    // Look-behind slot: remembers the channel decided last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_v    <= 1'b0;
            prv_hit  <= 1'b0;
            prv_chan <= '0;
        end else if (decide) begin
            prv_v    <= 1'b1;
            prv_hit  <= mid_hit;
            prv_chan <= mid_chan;
        end
    end

    // Output register: loaded by a kept channel, cleared once it is consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovld_q  <= 1'b0;
            oword_q <= '0;
        end else if (emit) begin
            ovld_q  <= 1'b1;
            oword_q <= {mid_chan, mid_corr, mid_tag};
        end else if (out_ready) begin
            ovld_q  <= 1'b0;
        end
    end

    assign out_valid = ovld_q;
    assign out_word  = oword_q;
endmodule

// File: rtl/strip_sparsifier.sv
// Module: top of the strip zero-suppressor. It joins the baseline table, the
// auto-zero comparator and the neighbour window. Assumes one channel per
// accepted cycle, presented in increasing index order within a scan.
module strip_sparsifier
    import strip_sparse_pkg::*;
#(
    parameter int N_CH   = N_CH_DEF,
    parameter int N_SAMP = N_SAMP_DEF,
    parameter int TAG_W  = TAG_W_DEF,
    localparam int CH_W   = $clog2(N_CH),
    localparam int SUM_W  = sum_width(SAMP_W, N_SAMP),
    localparam int WORD_W = CH_W + SUM_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [SUM_W-1:0]  in_sum,
    input  logic [SUM_W-1:0]  thresh,
    input  logic [TAG_W-1:0]  time_cnt,
    input  logic              ped_we,
    input  logic [CH_W-1:0]   ped_addr,
    input  logic [SUM_W-1:0]  ped_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] corr;
    logic             hit;

    strip_ped_table #(.N_CH(N_CH), .CH_W(CH_W), .SUM_W(SUM_W)) ped_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ped_we),
        .wr_addr (ped_addr),
        .wr_data (ped_data),
        .rd_addr (in_chan),
        .rd_data (base)
    );

    strip_autozero #(.SUM_W(SUM_W)) az_i (
        .sum    (in_sum),
        .base   (base),
        .thresh (thresh),
        .corr   (corr),
        .hit    (hit)
    );

    strip_nbr_window #(.N_CH(N_CH), .CH_W(CH_W), .SUM_W(SUM_W), .TAG_W(TAG_W)) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_chan   (in_chan),
        .in_corr   (corr),
        .in_hit    (hit),
        .in_tag    (time_cnt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );
endmodule

// File: rtl/strip_sparsifier_chk.sv
// Module: stream-discipline checker, attached to every instance of the top.
module strip_sparsifier_chk #(
    parameter int WORD_W = 37
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word
);
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);                  // R8
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_word));          // R8
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);                  // R8
    AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);                                  // R9
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);                              // R9
endmodule

bind strip_sparsifier strip_sparsifier_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
);

// File: tb/strip_sparsifier_tb_top.sv
module strip_sparsifier_tb_top;
    localparam int NCH    = 128;
    localparam int THRESH = 500;
    localparam int NSCN   = 7;

    // Scenario table: hit mask and output-ready pattern (0 always, 1 two of
    // three cycles, 2 one of four cycles)
    localparam logic [127:0] SCN_MASK [NSCN] = '{
        (128'd1 << 5),                                           // before baselines: R3
        128'd0,                                                  // no hits: R10
        (128'd1 << 10),                                          // isolated hit: R4
        (128'd1 << 0) | (128'd1 << 127),                         // edges: R6
        (128'd1 << 20) | (128'd1 << 22) | (128'd1 << 40) | (128'd1 << 41), // R5
        (((128'd1 << 11) - 128'd1) << 60),                       // run: R5
        (128'd1 << 100) | (128'd1 << 102) | (128'd1 << 104) | (128'd1 << 106) |
        (128'd1 << 126)                                          // R8
    };
    localparam int SCN_RDY [NSCN] = '{0, 0, 1, 0, 0, 1, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [6:0]  in_chan = '0;
    logic [13:0] in_sum = '0;
    logic [13:0] thresh = 14'(THRESH);
    logic [15:0] tcnt = '0;
    logic        ped_we = 1'b0;
    logic [6:0]  ped_addr = '0;
    logic [13:0] ped_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [36:0] out_word;

    int checks = 0;
    int errors = 0;
    int ped_m  [NCH];
    int sums   [NCH];
    int tag_m  [NCH];
    int exp_ch [NCH];
    int exp_n;

    always #2.5 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 16'd1;

    strip_sparsifier dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_chan(in_chan), .in_sum(in_sum), .thresh(thresh), .time_cnt(tcnt),
        .ped_we(ped_we), .ped_addr(ped_addr), .ped_data(ped_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ped(input int ch, input int val);
        @(negedge clk);
        ped_we = 1'b1; ped_addr = 7'(ch); ped_data = 14'(val);
        @(negedge clk);
        ped_we = 1'b0;
        ped_m[ch] = val;
    endtask

    function automatic int corr_of(input int ch);
        return (sums[ch] > ped_m[ch]) ? sums[ch] - ped_m[ch] : 0;
    endfunction

    function automatic void fill_sums(input logic [127:0] m);
        for (int c = 0; c < NCH; c++)
            sums[c] = m[c] ? ped_m[c] + THRESH + 1 + c * 20 : ped_m[c] + (c % 97) * 5;
    endfunction

    // Expected kept channels from the hit flags the bench derives itself
    function automatic void build_exp();
        bit h [NCH];
        exp_n = 0;
        for (int c = 0; c < NCH; c++) h[c] = (corr_of(c) > THRESH);
        for (int c = 0; c < NCH; c++)
            if (h[c] || (c > 0 && h[c-1]) || (c < NCH-1 && h[c+1])) begin
                exp_ch[exp_n] = c;
                exp_n++;
            end
    endfunction

    // Stream one full scan and compare every record that leaves
    task automatic run_scan(input int rdy, input string req);
        int sent = 0;
        int got = 0;
        int steps = 0;
        bit held = 1'b0;
        logic [36:0] held_w = '0;
        logic [36:0] ew;
        build_exp();
        while ((sent < NCH || got < exp_n) && steps < 3000) begin
            @(negedge clk);
            steps++;
            case (rdy)
                1:       out_ready = (tcnt % 3) != 0;
                2:       out_ready = (tcnt % 4) == 0;
                default: out_ready = 1'b1;
            endcase
            in_valid = (sent < NCH);
            in_chan  = 7'(sent % NCH);
            in_sum   = 14'(sums[sent % NCH]);
            #1;
            if (held) begin
                chk(out_valid && out_word == held_w, "R8 stalled record held", out_word, held_w);
                held = 1'b0;
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R8 input closed during stall", in_ready, 0);
                held = 1'b1; held_w = out_word;
            end
            if (out_valid && out_ready) begin
                if (got < exp_n) begin
                    ew = {7'(exp_ch[got]), 14'(corr_of(exp_ch[got])), 16'(tag_m[exp_ch[got]])};
                    chk(out_word == ew, req, out_word, ew);
                end else begin
                    chk(1'b0, {req, " R10 extra record"}, out_word, 0);
                end
                got++;
            end
            if (in_valid && in_ready) begin
                tag_m[sent] = int'(tcnt);
                sent++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (4) begin
            @(negedge clk); #1;
            if (out_valid) got++;
        end
        chk(got == exp_n, {req, " R5 record count"}, got, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) ped_m[c] = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R9 out_valid low in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid, "R9 out_valid low after reset", out_valid, 0);
        chk(in_ready, "R9 in_ready high after reset", in_ready, 1);

        for (int i = 0; i < NSCN; i++) begin
            if (i == 1)
                for (int c = 0; c < NCH; c++) write_ped(c, (c * 7) % 200);
            fill_sums(SCN_MASK[i]);
            run_scan(SCN_RDY[i], $sformatf("R4 R7 scan %0d", i));
        end

        // Directed: clamped baseline on a neighbour (R2), sum exactly at threshold (R1)
        write_ped(31, 16000);
        fill_sums(128'd1 << 32);
        sums[31] = 100;
        sums[80] = ped_m[80] + THRESH;
        run_scan(0, "R1 R2 clamp and equal threshold");

        // Directed: pedestal rewrite raises channel 50 above threshold (R3)
        write_ped(31, 0);
        write_ped(50, 0);
        fill_sums(128'd0);
        ped_m[50] = 0;
        sums[50] = THRESH + 1;
        run_scan(1, "R3 new baseline used");

        // Directed: reset in mid-scan leaves nothing pending (R9)
        @(negedge clk);
        in_valid = 1'b1; in_chan = 7'd9; in_sum = 14'd9000; out_ready = 1'b0;
        @(negedge clk);
        in_chan = 7'd10; in_sum = 14'd9000;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; out_ready = 1'b1;
        repeat (3) begin
            @(negedge clk); #1;
            chk(!out_valid, "R9 window empty after reset", out_valid, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule